// File: doc/BRIEF.md
# Prefix-Suffix Syntax Binarizer

This block turns one syntax element value into its bin string in a single registered step. It serves two syntax kinds whose code is a truncated prefix, followed by an Exp-Golomb suffix only when the prefix saturates.

- **Residual coefficient level.** The prefix is a truncated Rice code steered by a Rice parameter. The suffix is Exp-Golomb of order one higher than that parameter.
- **QP delta magnitude.** The prefix is truncated unary with a ceiling of five. The suffix is zeroth-order Exp-Golomb.

A one-bit kind select picks between the two. The result appears as a left-aligned bin word together with its length, for a context modeller and arithmetic coder placed after this block.

Each accepted input is marked by a valid strobe. The matching output carries a valid flag one clock later. Between strobes the output registers keep their last result.

Top module: `prefix_suffix_binarizer`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `out_bins`/`out_len` hold that input's code. When `in_valid` is low, `out_valid` goes low and `out_bins`/`out_len` keep their previous values.
- R2: A synchronous active-high `rst` clears `out_valid`, `out_bins` and `out_len` to zero, whatever the other inputs are.
- R3: QP delta kind (`in_kind`=1), value v below 5: the code is v one-bins followed by a zero-bin, with length v+1 (3 gives 1110).
- R4: QP delta kind, v of 5 or more: the code is five one-bins followed by the order-0 Exp-Golomb code of v-5 (5 gives 111110, 6 gives 11111100).
- R5: Coefficient kind (`in_kind`=0), with Rice parameter r and ceiling c = 4<<r, v below c: the code is (v>>r) one-bins, a zero-bin, then the r low bits of v, most significant first. The length is (v>>r)+1+r.
- R6: Coefficient kind, v of c or more: the code is four one-bins followed by the Exp-Golomb code of order r+1 for v-c.
- R7: The Exp-Golomb code of order k for s is built from t = s + 2^k and m, the index of t's highest set bit. It is (m-k) one-bins, a zero-bin, then the m low bits of t, most significant first. Its length is 2m-k+1.
- R8: The first bin of the code sits at `out_bins` bit 47 and later bins follow at lower bit positions. Every bit below the last bin is zero.
- R9: A Rice parameter of 5, 6 or 7 gives the same code as a Rice parameter of 4.
- R10: The full 16-bit value range is coded without truncation. Value 65535 gives 36 bins for the QP delta kind and 34 bins for the coefficient kind with r=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe: convert this cycle's inputs |
| in_kind | input | 1 | Syntax kind: 0 coefficient level, 1 QP delta |
| in_value | input | 16 | Unsigned value to binarize |
| in_rice | input | 3 | Rice parameter (coefficient kind only) |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_bins | output | 48 | Bin string, left-aligned |
| out_len | output | 6 | Number of bins in `out_bins` |

## Verification
The assertions check the following on every cycle:
- the valid flag follows the strobe with one cycle of delay, and the outputs hold between strobes;
- no stray bits lie beyond the stated length;
- a saturated QP prefix always leads with five one-bins;
- an unsaturated QP code always ends in a zero-bin;
- the suffix length always exceeds its Exp-Golomb order by an odd amount.

The exact bin patterns can only be shown by the bench's scenarios, which compare against an independently built bit-by-bit model. These patterns are the prefix/suffix boundary at each ceiling, the Rice low bits, Rice parameter clamping, the extreme values and the reset values.

// File: rtl/binz_pkg.sv
package binz_pkg;
  // Syntax kind selected by the one-bit in_kind port.
  typedef enum logic {
    KIND_COEF_REM = 1'b0,
    KIND_QP_DELTA = 1'b1
  } syn_kind_e;

  // Truncated-unary ceiling for the QP delta prefix.
  localparam int unsigned QP_PREFIX_CMAX = 5;
  // Number of one-bins in a saturated coefficient prefix (ceiling is this << rice).
  localparam int unsigned COEF_SAT_BINS  = 4;
endpackage

// File: rtl/binz_prefix.sv
module binz_prefix
  import binz_pkg::*;
#(
  parameter int unsigned VAL_W    = 16,
  parameter int unsigned RICE_W   = 3,
  parameter int unsigned RICE_MAX = 4,
  parameter int unsigned K_W      = 3,
  parameter int unsigned BIN_W    = 48,
  parameter int unsigned LEN_W    = 6
) (
  input  syn_kind_e          kind,
  input  logic [VAL_W-1:0]   value,
  input  logic [RICE_W-1:0]  rice,
  output logic [BIN_W-1:0]   pfx_code,   // right-aligned prefix bins
  output logic [LEN_W-1:0]   pfx_len,
  output logic               sat,        // prefix saturated: suffix follows
  output logic [VAL_W-1:0]   sfx_val,
  output logic [K_W-1:0]     sfx_k
);
  localparam logic [BIN_W-1:0] ONE_B = 1;

  function automatic logic [BIN_W-1:0] run_of_ones(input int unsigned n);
    return (ONE_B << n) - ONE_B;
  endfunction

  function automatic int unsigned clamp_rice(input logic [RICE_W-1:0] r);
    int unsigned ru;
    ru = 32'(r);
    return (ru > RICE_MAX) ? RICE_MAX : ru;
  endfunction

  int unsigned v_u, r_eff, cmax_u, q_u;
  logic        qp_sat, coef_sat;

  assign v_u      = 32'(value);
  assign r_eff    = clamp_rice(rice);
  assign cmax_u   = COEF_SAT_BINS << r_eff;
  assign q_u      = v_u >> r_eff;
  assign qp_sat   = (v_u >= QP_PREFIX_CMAX);
  assign coef_sat = (v_u >= cmax_u);

  always_comb begin
    pfx_code = '0;
    pfx_len  = '0;
    sat      = 1'b0;
    sfx_val  = '0;
    sfx_k    = '0;
    case (kind)
      KIND_QP_DELTA: begin
        if (qp_sat) begin
          pfx_code = run_of_ones(QP_PREFIX_CMAX);
          pfx_len  = LEN_W'(QP_PREFIX_CMAX);
          sat      = 1'b1;
          sfx_val  = VAL_W'(v_u - QP_PREFIX_CMAX);
          sfx_k    = '0;
        end else begin
          pfx_code = run_of_ones(v_u) << 1;
          pfx_len  = LEN_W'(v_u + 1);
        end
      end
      default: begin
        if (coef_sat) begin
          pfx_code = run_of_ones(COEF_SAT_BINS);
          pfx_len  = LEN_W'(COEF_SAT_BINS);
          sat      = 1'b1;
          sfx_val  = VAL_W'(v_u - cmax_u);
          sfx_k    = K_W'(r_eff + 1);
        end else begin
          pfx_code = (run_of_ones(q_u) << (r_eff + 1))
                   | (BIN_W'(v_u) & run_of_ones(r_eff));
          pfx_len  = LEN_W'(q_u + 1 + r_eff);
        end
      end
    endcase
  end
endmodule

// File: rtl/binz_egk.sv
module binz_egk #(
  parameter int unsigned VAL_W = 16,
  parameter int unsigned K_W   = 3,
  parameter int unsigned BIN_W = 48,
  parameter int unsigned LEN_W = 6
) (
  input  logic [VAL_W-1:0] sfx_val,
  input  logic [K_W-1:0]   order,
  output logic [BIN_W-1:0] code,      // right-aligned suffix bins
  output logic [LEN_W-1:0] len
);
  localparam int unsigned T_W = VAL_W + 1;
  localparam logic [BIN_W-1:0] ONE_B = 1;
  localparam logic [T_W-1:0]   ONE_T = 1;

  function automatic logic [BIN_W-1:0] run_of_ones(input int unsigned n);
    return (ONE_B << n) - ONE_B;
  endfunction

  // Index of the highest set bit (zero for an all-zero word).
  function automatic int unsigned top_one(input logic [T_W-1:0] x);
    int unsigned p;
    p = 0;
    for (int i = 0; i < int'(T_W); i++) begin
      if (x[i]) p = i;
    end
    return p;
  endfunction

  logic [T_W-1:0] biased;
  int unsigned    msb_pos, lead_ones;

  assign biased    = T_W'(sfx_val) + (ONE_T << order);
  assign msb_pos   = top_one(biased);
  assign lead_ones = msb_pos - 32'(order);
  assign code      = (run_of_ones(lead_ones) << (msb_pos + 1))
                   | (BIN_W'(biased) & run_of_ones(msb_pos));
  assign len       = LEN_W'(2 * msb_pos - 32'(order) + 1);
endmodule

// File: rtl/binz_join.sv
module binz_join #(
  parameter int unsigned BIN_W = 48,
  parameter int unsigned LEN_W = 6
) (
  input  logic [BIN_W-1:0] pfx_code,
  input  logic [LEN_W-1:0] pfx_len,
  input  logic             sfx_present,
  input  logic [BIN_W-1:0] sfx_code,
  input  logic [LEN_W-1:0] sfx_len,
  output logic [BIN_W-1:0] word,
  output logic [LEN_W-1:0] word_len
);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(BIN_W);

  logic [BIN_W-1:0] pfx_left, sfx_left;

  assign pfx_left = pfx_code << (FULL - pfx_len);
  assign sfx_left = sfx_code << (FULL - sfx_len);
  assign word     = sfx_present ? (pfx_left | (sfx_left >> pfx_len)) : pfx_left;
  assign word_len = sfx_present ? (pfx_len + sfx_len) : pfx_len;
endmodule

// File: rtl/prefix_suffix_binarizer.sv
module prefix_suffix_binarizer
  import binz_pkg::*;
#(
  parameter int unsigned VAL_W    = 16,
  parameter int unsigned RICE_W   = 3,
  parameter int unsigned RICE_MAX = 4,
  parameter int unsigned BIN_W    = 48,
  parameter int unsigned LEN_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_kind,
  input  logic [VAL_W-1:0]  in_value,
  input  logic [RICE_W-1:0] in_rice,
  output logic              out_valid,
  output logic [BIN_W-1:0]  out_bins,
  output logic [LEN_W-1:0]  out_len
);
  localparam int unsigned K_W = $clog2(RICE_MAX + 2);

  syn_kind_e        kind_e;
  logic [BIN_W-1:0] pfx_code, sfx_code, comb_bins;
  logic [LEN_W-1:0] pfx_len_w, sfx_len_w, comb_len;
  logic             pfx_sat;
  logic [VAL_W-1:0] sfx_val;
  logic [K_W-1:0]   sfx_k;

  assign kind_e = syn_kind_e'(in_kind);

  binz_prefix #(
    .VAL_W(VAL_W), .RICE_W(RICE_W), .RICE_MAX(RICE_MAX),
    .K_W(K_W), .BIN_W(BIN_W), .LEN_W(LEN_W)
  ) i_prefix (
    .kind(kind_e), .value(in_value), .rice(in_rice),
    .pfx_code(pfx_code), .pfx_len(pfx_len_w), .sat(pfx_sat),
    .sfx_val(sfx_val), .sfx_k(sfx_k)
  );

  binz_egk #(
    .VAL_W(VAL_W), .K_W(K_W), .BIN_W(BIN_W), .LEN_W(LEN_W)
  ) i_egk (
    .sfx_val(sfx_val), .order(sfx_k), .code(sfx_code), .len(sfx_len_w)
  );

  binz_join #(.BIN_W(BIN_W), .LEN_W(LEN_W)) i_join (
    .pfx_code(pfx_code), .pfx_len(pfx_len_w), .sfx_present(pfx_sat),
    .sfx_code(sfx_code), .sfx_len(sfx_len_w),
    .word(comb_bins), .word_len(comb_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bins  <= '0;
      out_len   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_bins <= comb_bins;
        out_len  <= comb_len;
      end
    end
  end

  // R1: strobe to flag, one cycle
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_bins) && $stable(out_len)));

  // R8: nothing past the last bin
  p_zero_tail_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_bins << out_len) == '0));

  // R4: saturated QP prefix leads with five ones and carries a suffix
  p_qp_sat_lead_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind_e == KIND_QP_DELTA && pfx_sat) |->
      (comb_bins[BIN_W-1 -: QP_PREFIX_CMAX] == '1 && comb_len > LEN_W'(QP_PREFIX_CMAX)));

  // R3: unsaturated QP code ends in a zero-bin
  p_qp_short_end_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind_e == KIND_QP_DELTA && !pfx_sat) |->
      (((comb_bins >> (LEN_W'(BIN_W) - comb_len)) & BIN_W'(1)) == '0));

  // R7: suffix length exceeds its order by an odd count
  p_egk_len_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pfx_sat) |->
      (sfx_len_w > LEN_W'(sfx_k) && (((sfx_len_w - LEN_W'(sfx_k)) & LEN_W'(1)) != '0)));
endmodule

// File: tb/test_prefix_suffix_binarizer.sv
`timescale 1ns/1ps
module test_prefix_suffix_binarizer;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_kind;
  logic [15:0] in_value;
  logic [2:0]  in_rice;
  logic        out_valid;
  logic [47:0] out_bins;
  logic [5:0]  out_len;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prefix_suffix_binarizer i_prefix_suffix_binarizer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
    .in_value(in_value), .in_rice(in_rice),
    .out_valid(out_valid), .out_bins(out_bins), .out_len(out_len)
  );

  // Bit-serial reference model
  logic [47:0] ref_bins;
  int          ref_len;

  function automatic void push_bin(input bit b);
    ref_bins[47 - ref_len] = b;
    ref_len++;
  endfunction

  function automatic void push_egk(input int s, input int k);
    while (s >= (1 << k)) begin
      push_bin(1'b1);
      s = s - (1 << k);
      k++;
    end
    push_bin(1'b0);
    while (k > 0) begin
      k--;
      push_bin(((s >> k) & 1) != 0);
    end
  endfunction

  function automatic void build_ref(input bit kind, input int v, input int r);
    int rr, c;
    ref_bins = '0;
    ref_len  = 0;
    if (kind) begin
      for (int i = 0; i < ((v < 5) ? v : 5); i++) push_bin(1'b1);
      if (v < 5) push_bin(1'b0);
      else push_egk(v - 5, 0);
    end else begin
      rr = (r > 4) ? 4 : r;
      c  = 4 << rr;
      if (v < c) begin
        for (int i = 0; i < (v >> rr); i++) push_bin(1'b1);
        push_bin(1'b0);
        for (int b = rr - 1; b >= 0; b--) push_bin(((v >> b) & 1) != 0);
      end else begin
        for (int i = 0; i < 4; i++) push_bin(1'b1);
        push_egk(v - c, rr + 1);
      end
    end
  endfunction

  task automatic check_out(input string tag, input bit ev, input logic [47:0] eb, input int el);
    vecs++;
    if (out_valid !== ev || out_bins !== eb || out_len !== el[5:0]) begin
      errs++;
      $display("FAIL %s: got valid=%0b bins=%h len=%0d, expected valid=%0b bins=%h len=%0d",
               tag, out_valid, out_bins, out_len, ev, eb, el);
    end
  endtask

  task automatic run_one(input string tag, input bit kind, input int v, input int r);
    @(negedge clk);
    in_valid = 1'b1; in_kind = kind; in_value = 16'(v); in_rice = 3'(r);
    @(negedge clk);
    in_valid = 1'b0;
    build_ref(kind, v, r);
    check_out(tag, 1'b1, ref_bins, ref_len);
  endtask

  // R2: reset clears outputs regardless of inputs
  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_kind = 1'b1; in_value = 16'd999; in_rice = 3'd2;
    @(negedge clk);
    @(negedge clk);
    check_out("R2 reset", 1'b0, 48'h0, 0);
    in_valid = 1'b0;
    rst = 1'b0;
  endtask

  // R3/R4: literal examples, written out independently of the model
  task automatic t_qp_literals();
    run_one("R3 qp literal", 1'b1, 3, 0);
    check_out("R3 qp 3 -> 1110", 1'b1, {4'b1110, 44'd0}, 4);
    run_one("R4 qp literal", 1'b1, 5, 0);
    check_out("R4 qp 5 -> 111110", 1'b1, {6'b111110, 42'd0}, 6);
    run_one("R4 qp literal", 1'b1, 6, 0);
    check_out("R4 qp 6 -> 11111100", 1'b1, {8'b11111100, 40'd0}, 8);
    run_one("R3 qp literal", 1'b1, 0, 0);
    check_out("R3 qp 0 -> 0", 1'b1, 48'h0, 1);
  endtask

  // R3/R4/R7: QP sweep across the saturation boundary
  task automatic t_qp_sweep();
    for (int v = 0; v < 80; v++) run_one(v < 5 ? "R3 qp sweep" : "R4 R7 qp sweep", 1'b1, v, v % 8);
  endtask

  // R5/R6/R7: coefficient kind for every Rice parameter, around the ceiling
  task automatic t_coef_sweep();
    for (int r = 0; r <= 4; r++) begin
      for (int v = 0; v < (4 << r) + 40; v++)
        run_one(v < (4 << r) ? "R5 coef below ceiling" : "R6 R7 coef above ceiling", 1'b0, v, r);
    end
    run_one("R5 coef literal", 1'b0, 5, 1);
    check_out("R5 coef 5 r1 -> 1101", 1'b1, {4'b1101, 44'd0}, 4);
    run_one("R6 coef literal", 1'b0, 4, 0);
    check_out("R6 coef 4 r0 -> 111100", 1'b1, {6'b111100, 42'd0}, 6);
  endtask

  // R9: Rice parameters above 4 act as 4
  task automatic t_rice_clamp();
    for (int r = 5; r <= 7; r++) begin
      for (int v = 0; v < 200; v += 7) begin
        @(negedge clk);
        in_valid = 1'b1; in_kind = 1'b0; in_value = 16'(v); in_rice = 3'(r);
        @(negedge clk);
        in_valid = 1'b0;
        build_ref(1'b0, v, 4);
        check_out("R9 rice clamp", 1'b1, ref_bins, ref_len);
      end
    end
  endtask

  // R10: extreme values
  task automatic t_extremes();
    run_one("R10 qp max", 1'b1, 65535, 0);
    if (out_len !== 6'd36) begin
      errs++; $display("FAIL R10 qp max length: got %0d expected 36", out_len);
    end
    vecs++;
    run_one("R10 coef max r0", 1'b0, 65535, 0);
    if (out_len !== 6'd34) begin
      errs++; $display("FAIL R10 coef max length: got %0d expected 34", out_len);
    end
    vecs++;
    run_one("R10 coef max r4", 1'b0, 65535, 4);
    run_one("R10 coef mid r2", 1'b0, 32768, 2);
  endtask

  // R1: outputs hold while no strobe, flag drops
  task automatic t_hold();
    logic [47:0] kept_bins;
    int          kept_len;
    run_one("R1 hold setup", 1'b1, 37, 0);
    kept_bins = ref_bins;
    kept_len  = ref_len;
    @(negedge clk);
    in_kind = 1'b0; in_value = 16'd12345; in_rice = 3'd3;
    @(negedge clk);
    @(negedge clk);
    check_out("R1 hold without strobe", 1'b0, kept_bins, kept_len);
  endtask

  // R1/R8: back-to-back strobes, one result per cycle
  task automatic t_stream();
    bit          pk;
    int          pv, pr;
    for (int i = 0; i <= 60; i++) begin
      @(negedge clk);
      if (i > 0) begin
        build_ref(pk, pv, pr);
        check_out("R1 R8 back-to-back", 1'b1, ref_bins, ref_len);
      end
      if (i < 60) begin
        pk = ($urandom_range(0, 1) != 0);
        pv = (i % 3 == 0) ? int'($urandom_range(0, 65535)) : int'($urandom_range(0, 90));
        pr = int'($urandom_range(0, 7));
        in_valid = 1'b1; in_kind = pk; in_value = 16'(pv); in_rice = 3'(pr);
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_kind = 1'b0; in_value = '0; in_rice = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_qp_literals();
    t_qp_sweep();
    t_coef_sweep();
    t_rice_clamp();
    t_extremes();
    t_hold();
    t_stream();
    t_reset();
    run_one("R2 after reset", 1'b1, 9, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(4ns * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule